// File: doc/BRIEF.md
# Quadrature Encoder Position Interface

The block turns the two phase signals of an incremental rotary encoder and its once-per-turn index signal into a 16-bit position count. The phases and the index are first resynchronised to the system clock. A small decoder state machine then follows the Gray-code state of the phase pair. Each legal transition is classified as forward or reverse. In forward rotation, phase A leads phase B. A 3-bit mode field enables the block. It also chooses between counting every phase edge (4x) or only phase-A edges (2x), and chooses whether the count is reset by the index edge or wraps at a programmable maximum.

The block reports the direction of the last counted step. In the index-reset modes, it latches a sticky error flag when the count rolls over in either direction. Every counted step also feeds a prescaler that emits one velocity pulse per 1, 4, 16 or 64 steps. Software reaches three registers through a synchronous write port and a combinational read port: control, position and maximum count. The encoder shares its pins with an input-capture function. While the encoder is enabled, it keeps that capture function switched off.

The decoder state machine has four states, each named after the synchronised (A,B) level pair it has last seen: Q00, Q10, Q11 and Q01. The forward transitions are Q00→Q10, Q10→Q11, Q11→Q01 and Q01→Q00. The reverse transitions run the other way: Q00→Q01, Q01→Q11, Q11→Q10 and Q10→Q00. The two double-bit jumps, Q00↔Q11 and Q10↔Q01, are illegal. On an illegal jump the state machine moves to the new state but reports no step. When the input does not change, the state is held.

Top module: `qenc_pos_if`

## Requirements
- R1: The control register lives at address 0. Its fields are: bits [2:0] mode, bits [4:3] velocity divide, bit 5 velocity disable, bit 6 error, and bit 7 direction. Only mode codes 001, 010, 101 and 110 enable the encoder. Codes 000, 011, 100 and 111 leave it off. While off, the position holds and no velocity pulse is produced.
- R2: With mode bit 2 set (4x), every legal transition of the phase pair changes the position by one. With mode bit 2 clear (2x), only legal transitions in which phase A changes are counted.
- R3: The forward sequence on (A,B) is 00→10→11→01→00. Forward steps increment the position and reverse steps decrement it. Control bit 7 reads 1 after a counted forward step and 0 after a counted reverse step. Writes cannot change it.
- R4: A transition in which both phases change at once produces no count.
- R5: In index modes (mode bits [1:0] = 01), a rising edge of the synchronised index input clears the position to zero. This takes priority over a step in the same cycle. A held-high index clears the position only once.
- R6: In max-count modes (mode bits [1:0] = 10), a forward step at position = maximum count yields 0. A reverse step at position 0 loads the maximum count.
- R7: The error bit (control bit 6) is set only in index modes, when a forward step wraps the position from 0xFFFF to 0 or a reverse step wraps it from 0 to 0xFFFF. Once set, it stays set. A control write with bit 6 at 0 clears it. A write with bit 6 at 1 leaves it unchanged.
- R8: With control bit 5 at 0 and the encoder on, the block issues one single-cycle velocity pulse per N counted steps. N is 1, 4, 16 or 64 for velocity divide codes 00, 01, 10 and 11. With bit 5 at 1, no pulse is issued.
- R9: The capture-enable output is high only when the capture request is high and the encoder is off.
- R10: After reset, all three registers read zero. Address 1 holds the position and address 2 holds the maximum count. Both can be written. Address 3 reads zero. A position write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Phase A, asynchronous |
| enc_b | input | 1 | Phase B, asynchronous |
| enc_idx | input | 1 | Index, asynchronous |
| cap_req | input | 1 | Input-capture function requests the shared pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 position, 2 max count) |
| wr_data | input | 16 | Write data (control uses bits 7:0) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| vel_pulse | output | 1 | Decimated velocity pulse |
| cap_active | output | 1 | Input-capture function allowed to run |

## Verification
Several properties are checked by assertions on every cycle:
- An illegal double-bit jump never produces a step.
- A disabled encoder never moves the position or pulses.
- A velocity pulse always follows a counted step.
- The error flag stays set until a clearing write.
- The index edge and the max-count wrap land on their required values.
- The capture enable and the encoder enable are never high together.

The bench scenarios are needed to show counting by whole sequences:
- the 2x-versus-4x count ratio over whole cycles;
- the exact number of velocity pulses per divide setting;
- the underflow load of the maximum count;
- the direction bit following reversals.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    // Decoder state named after the synchronised (A,B) level pair.
    typedef enum logic [1:0] {
        Q00 = 2'b00,
        Q01 = 2'b01,
        Q10 = 2'b10,
        Q11 = 2'b11
    } qstate_t;

    typedef struct packed {
        logic       dir;
        logic       err;
        logic       vel_off;
        logic [1:0] div;
        logic [2:0] mode;
    } ctrl_t;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_POS  = 2'd1;
    localparam logic [1:0] ADR_MAX  = 2'd2;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= din[i];
                s2 <= s1;
            end
        end
        assign dout[i] = s2;
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic step_fwd,
    output logic step_rev,
    output logic a_moved
);
    qstate_t state_q, cur, fwd_nxt, rev_nxt;

    assign cur = qstate_t'({a, b});

    // State register: always follows the observed level pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q00;
        else        state_q <= cur;
    end

    // Output logic: classify the move from the held state to the current pair.
    always_comb begin
        unique case (state_q)
            Q00: begin fwd_nxt = Q10; rev_nxt = Q01; end
            Q10: begin fwd_nxt = Q11; rev_nxt = Q00; end
            Q11: begin fwd_nxt = Q01; rev_nxt = Q10; end
            Q01: begin fwd_nxt = Q00; rev_nxt = Q11; end
        endcase
        step_fwd = (cur == fwd_nxt);
        step_rev = (cur == rev_nxt);
        a_moved  = cur[1] ^ state_q[1];
    end

    a_r4_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((a ^ state_q[1]) && (b ^ state_q[0])) |-> !(step_fwd || step_rev));
    a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_fwd && step_rev));
endmodule

// File: rtl/qenc_velo.sv
module qenc_velo #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             pulse
);
    localparam int CNT_W = 2 * ((1 << DIV_W) - 1);

    logic [CNT_W-1:0] cnt_q, limit;

    // Divide ratio is 4**div.
    always_comb limit = CNT_W'((1 << (2 * div)) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (!active) begin
                cnt_q <= '0;
            end else if (step) begin
                if (cnt_q == limit) begin
                    cnt_q <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    a_r8_pulse_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(active && step));
endmodule

// File: rtl/qenc_pos_if.sv
module qenc_pos_if
    import qenc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             cap_req,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [POS_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [POS_W-1:0] rd_data,
    output logic             vel_pulse,
    output logic             cap_active
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic [2:0] sync_q;
    logic       idx_prev_q, idx_rise;
    logic       fwd, rev, a_moved;
    ctrl_t      ctrl_q;
    logic [POS_W-1:0] pos_q, max_q;
    logic enc_on, idx_mode, max_mode, cnt_step, ovf;
    logic ctrl_wr, pos_wr, max_wr;

    qenc_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({enc_idx, enc_a, enc_b}),
        .dout(sync_q)
    );

    qenc_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .a(sync_q[1]), .b(sync_q[0]),
        .step_fwd(fwd), .step_rev(rev), .a_moved(a_moved)
    );

    always_comb begin
        unique case (ctrl_q.mode)
            3'b001, 3'b010, 3'b101, 3'b110: enc_on = 1'b1;
            default:                        enc_on = 1'b0;
        endcase
        idx_mode = enc_on && (ctrl_q.mode[1:0] == 2'b01);
        max_mode = enc_on && (ctrl_q.mode[1:0] == 2'b10);
        cnt_step = enc_on && (fwd || rev) && (ctrl_q.mode[2] || a_moved);
        idx_rise = sync_q[2] && !idx_prev_q;
        ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
        pos_wr   = wr_en && (wr_addr == ADR_POS);
        max_wr   = wr_en && (wr_addr == ADR_MAX);
        ovf      = idx_mode && cnt_step && !idx_rise && !pos_wr &&
                   ((fwd && (&pos_q)) || (rev && (pos_q == '0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_prev_q <= 1'b0;
            ctrl_q     <= '0;
            pos_q      <= '0;
            max_q      <= '0;
        end else begin
            idx_prev_q <= sync_q[2];
            if (ctrl_wr) begin
                ctrl_q.mode    <= wr_data[2:0];
                ctrl_q.div     <= wr_data[4:3];
                ctrl_q.vel_off <= wr_data[5];
            end
            if (ovf)                        ctrl_q.err <= 1'b1;
            else if (ctrl_wr && !wr_data[6]) ctrl_q.err <= 1'b0;
            if (cnt_step) ctrl_q.dir <= fwd;
            if (max_wr) max_q <= wr_data;
            if (pos_wr) begin
                pos_q <= wr_data;
            end else if (idx_mode && idx_rise) begin
                pos_q <= '0;
            end else if (cnt_step) begin
                if (fwd) pos_q <= (max_mode && pos_q == max_q) ? '0 : pos_q + 1'b1;
                else     pos_q <= (max_mode && pos_q == '0) ? max_q : pos_q - 1'b1;
            end
        end
    end

    qenc_velo #(.DIV_W(2)) u_velo (
        .clk(clk), .rst_n(rst_n),
        .active(enc_on && !ctrl_q.vel_off),
        .step(cnt_step),
        .div(ctrl_q.div),
        .pulse(vel_pulse)
    );

    assign cap_active = cap_req && !enc_on;

    always_comb begin
        unique case (rd_addr)
            ADR_CTRL: rd_data = POS_W'(ctrl_q);
            ADR_POS:  rd_data = pos_q;
            ADR_MAX:  rd_data = max_q;
            default:  rd_data = '0;
        endcase
    end

    // Assertions
    a_r1_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_on && !pos_wr) |=> $stable(pos_q));
    a_r1_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_on && !ctrl_wr) |=> !vel_pulse);
    a_r5_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_mode && idx_rise && !pos_wr) |=> (pos_q == '0));
    a_r6_max_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (max_mode && fwd && cnt_step && pos_q == max_q && !pos_wr) |=> (pos_q == '0));
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.err && !(ctrl_wr && !wr_data[6])) |=> ctrl_q.err);
    a_r3_dir_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && fwd) |=> ctrl_q.dir);
    a_r9_cap_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_active && enc_on));

    initial begin
        a_r10_ctrl_fits: assert (CTRL_W <= POS_W);
    end
endmodule

// File: tb/tb_qenc_pos_if.sv
module tb_qenc_pos_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, cap_req = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic vel_pulse, cap_active;
    int checks = 0, fails = 0, vcnt = 0;

    always #5 clk = ~clk;

    qenc_pos_if dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .cap_req(cap_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vel_pulse(vel_pulse), .cap_active(cap_active)
    );

    always @(negedge clk) if (vel_pulse) vcnt++;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] adr, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = adr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(string req, logic [1:0] adr, logic [15:0] exp);
        rd_addr = adr;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic fwd(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case ({enc_a, enc_b})
                2'b00: {enc_a, enc_b} = 2'b10;
                2'b10: {enc_a, enc_b} = 2'b11;
                2'b11: {enc_a, enc_b} = 2'b01;
                default: {enc_a, enc_b} = 2'b00;
            endcase
            settle();
        end
    endtask

    task automatic rev(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case ({enc_a, enc_b})
                2'b00: {enc_a, enc_b} = 2'b01;
                2'b01: {enc_a, enc_b} = 2'b11;
                2'b11: {enc_a, enc_b} = 2'b10;
                default: {enc_a, enc_b} = 2'b00;
            endcase
            settle();
        end
    endtask

    task automatic t_reset();
        rd("R10 ctrl reset", 2'd0, 16'h0000);
        rd("R10 pos reset", 2'd1, 16'h0000);
        rd("R10 max reset", 2'd2, 16'h0000);
        rd("R10 addr3", 2'd3, 16'h0000);
        chk("R9 cap when off", {15'd0, cap_active}, 16'd1);
    endtask

    task automatic t_off();
        wr(2'd1, 16'h0040);
        vcnt = 0;
        fwd(4);
        rd("R1 mode 000 holds", 2'd1, 16'h0040);
        wr(2'd0, 16'h0003);
        fwd(4);
        rd("R1 mode 011 holds", 2'd1, 16'h0040);
        wr(2'd0, 16'h0007);
        rev(3);
        rd("R1 mode 111 holds", 2'd1, 16'h0040);
        chk("R1 no pulses off", 16'(vcnt), 16'd0);
        chk("R9 cap when 111", {15'd0, cap_active}, 16'd1);
    endtask

    task automatic t_x4();
        wr(2'd0, 16'h0025);  // 4x index, velocity off
        chk("R9 cap blocked", {15'd0, cap_active}, 16'd0);
        wr(2'd1, 16'd100);
        fwd(8);
        rd("R2 4x forward", 2'd1, 16'd108);
        rd("R3 dir forward", 2'd0, 16'h00A5);
        rev(3);
        rd("R3 4x reverse", 2'd1, 16'd105);
        rd("R3 dir reverse", 2'd0, 16'h0025);
        wr(2'd0, 16'h00A5);  // attempt to write dir=1
        rd("R3 dir read-only", 2'd0, 16'h0025);
    endtask

    task automatic t_x2();
        wr(2'd0, 16'h0021);  // 2x index
        wr(2'd1, 16'd10);
        fwd(8);
        rd("R2 2x forward", 2'd1, 16'd14);
        rev(4);
        rd("R2 2x reverse", 2'd1, 16'd12);
    endtask

    task automatic t_illegal();
        wr(2'd0, 16'h0025);
        wr(2'd1, 16'd50);
        @(negedge clk);
        {enc_a, enc_b} = ~{enc_a, enc_b};
        settle();
        rd("R4 double jump ignored", 2'd1, 16'd50);
        fwd(1);
        rd("R4 resume after jump", 2'd1, 16'd51);
    endtask

    task automatic t_index();
        wr(2'd0, 16'h0025);
        wr(2'd1, 16'd77);
        @(negedge clk); enc_idx = 1'b1;
        settle();
        rd("R5 index clears", 2'd1, 16'd0);
        fwd(1);
        rd("R5 held index once", 2'd1, 16'd1);
        @(negedge clk); enc_idx = 1'b0;
        settle();
        wr(2'd0, 16'h0026);  // max mode: index ignored
        wr(2'd2, 16'd9);
        wr(2'd1, 16'd3);
        @(negedge clk); enc_idx = 1'b1;
        settle();
        rd("R5 index only in index mode", 2'd1, 16'd3);
        @(negedge clk); enc_idx = 1'b0;
        settle();
    endtask

    task automatic t_max();
        wr(2'd0, 16'h0026);
        wr(2'd2, 16'd5);
        wr(2'd1, 16'd4);
        fwd(1);
        rd("R6 reach max", 2'd1, 16'd5);
        fwd(1);
        rd("R6 wrap to zero", 2'd1, 16'd0);
        rev(1);
        rd("R6 underflow loads max", 2'd1, 16'd5);
        rd("R7 no err in max mode", 2'd0, 16'h0026);
    endtask

    task automatic t_err();
        wr(2'd0, 16'h0025);
        wr(2'd1, 16'hFFFF);
        fwd(1);
        rd("R7 overflow wraps", 2'd1, 16'h0000);
        rd("R7 err set", 2'd0, 16'h00E5);
        wr(2'd0, 16'h0065);
        rd("R7 write 1 keeps", 2'd0, 16'h00E5);
        wr(2'd0, 16'h0025);
        rd("R7 write 0 clears", 2'd0, 16'h00A5);
        rev(1);
        rd("R7 underflow wraps", 2'd1, 16'hFFFF);
        rd("R7 err on underflow", 2'd0, 16'h0065);
        wr(2'd0, 16'h0025);
    endtask

    task automatic t_vel();
        wr(2'd0, 16'h000D);  // 4x index, div /4, enabled
        vcnt = 0;
        fwd(8);
        chk("R8 div4", 16'(vcnt), 16'd2);
        wr(2'd0, 16'h0025);  // disable clears prescaler
        wr(2'd0, 16'h0005);  // div /1
        vcnt = 0;
        fwd(5);
        chk("R8 div1", 16'(vcnt), 16'd5);
        wr(2'd0, 16'h0025);
        wr(2'd0, 16'h0015);  // div /16
        vcnt = 0;
        rev(16);
        chk("R8 div16", 16'(vcnt), 16'd1);
        wr(2'd0, 16'h0025);
        wr(2'd0, 16'h001D);  // div /64
        vcnt = 0;
        fwd(63);
        chk("R8 div64 before", 16'(vcnt), 16'd0);
        fwd(1);
        chk("R8 div64 at 64", 16'(vcnt), 16'd1);
        wr(2'd0, 16'h0025);
        vcnt = 0;
        fwd(4);
        chk("R8 disabled", 16'(vcnt), 16'd0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_x4();
        t_x2();
        t_illegal();
        t_index();
        t_max();
        t_err();
        t_vel();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule